// File: doc/BRIEF.md
# Energy-Efficient Ethernet Low-Power-Idle Controller

This block decides when the transmit side of an Ethernet MAC may enter low-power idle (LPI) and when it may send frames again. It also records LPI transitions seen on the receive side. Software programs two words through a small register port. The control/status word holds the request bits, a software copy of the PHY link state, an interrupt enable and four sticky event flags. The timer word holds a link-stable time in milliseconds and a wake time in microseconds. Two free-running tick inputs, one per microsecond and one per millisecond, pace both waits.

Entry into LPI needs two things. First, LPI must be requested. Second, the link must have been reported up, without a break, for the programmed number of millisecond ticks. When the automatic mode is used, the transmit path must also be idle. Leaving LPI starts a wake window. Until that window has counted the programmed number of microsecond ticks, the resume-allowed output stays low. Producing the LPI code on the media interface is left to the transmit logic that follows this block.

Top module: `eee_lpi_ctrl`

## Requirements
- R1: The timer word (reg_addr=1) keeps the wake time in bits 15:0 and the link-stable time in bits 26:16. Bits 31:27 read as 0.
- R2: LPI is entered only after at least LS millisecond ticks with the link bit set. The count restarts from zero whenever the link bit is cleared.
- R3: While the link bit (control bit 18) is clear, LPI is not entered. Clearing it while in LPI forces an exit.
- R4: Either the LPI enable bit (control bit 16) or the auto bit (control bit 17) requests LPI. Clearing both while in LPI forces an exit.
- R5: With the auto bit set, entry waits for tx_idle high. A tx_frame_req pulse while in LPI forces an exit.
- R6: tx_lpi_req is high exactly while in LPI. After an exit, tx_resume_ok stays low until TW microsecond ticks have been counted in the wake window.
- R7: Control/status bits 0 to 3 are sticky flags: transmit entered LPI, transmit left LPI, receive entered LPI (rising rx_lpi), receive left LPI (falling rx_lpi). Bit 8 reads 1 while transmit is in LPI. Bit 9 reads 1 while the registered rx_lpi is 1.
- R8: A read strobe at reg_addr=0 clears the four flags at the next edge. A flag raised in the same cycle as that read stays set.
- R9: irq equals control bit 19 ANDed with the OR of the four flags.
- R10: After reset, every control bit and flag is 0, tx_lpi_req=0, tx_resume_ok=1 and irq=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (clears flags when reg_addr=0) |
| reg_addr | input | 1 | 0 = control/status word, 1 = timer word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| us_tick | input | 1 | One-cycle pulse every microsecond |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| tx_idle | input | 1 | Transmit path has nothing to send |
| tx_frame_req | input | 1 | A new frame wants to go out |
| rx_lpi | input | 1 | Receive side reports LPI |
| tx_lpi_req | output | 1 | Transmit should signal LPI |
| tx_resume_ok | output | 1 | Normal transmission allowed |
| irq | output | 1 | LPI event interrupt |

## Verification
The hardest case to reach from the ports is an rx_lpi edge that lands in the same cycle as a clearing read. The stimulus raises rx_lpi and the read strobe together, then checks two things: the read data of that cycle shows no flag, and a second read shows the receive-entry flag. The restart of the link-stable count is also hard to observe, because the count itself is not visible. The stimulus reaches it by dropping the link bit after one of two required millisecond ticks. It then shows that a single further tick does not cause entry, while a second one does.

// File: rtl/eee_lpi_pkg.sv
package eee_lpi_pkg;
    localparam int DATA_W     = 32;
    localparam int NUM_FLAGS  = 4;
    localparam int FLG_TX_IN  = 0;
    localparam int FLG_TX_OUT = 1;
    localparam int FLG_RX_IN  = 2;
    localparam int FLG_RX_OUT = 3;
    localparam int STS_TX_LPI = 8;
    localparam int STS_RX_LPI = 9;
    localparam int CB_LPI_EN  = 16;
    localparam int CB_AUTO    = 17;
    localparam int CB_LINK    = 18;
    localparam int CB_IRQ_EN  = 19;
    localparam int LS_LSB     = 16;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LPI  = 2'd1,
        ST_WAKE = 2'd2
    } lpi_state_e;

    typedef struct packed {
        logic lpi_en;
        logic tx_auto;
        logic link_ok;
        logic irq_en;
    } lpi_cfg_t;
endpackage

// File: rtl/eee_lpi_tick_cnt.sv
module eee_lpi_tick_cnt #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_CNT = '1;

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick && cnt_q != MAX_CNT) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/eee_lpi_regs.sv
module eee_lpi_regs
    import eee_lpi_pkg::*;
#(
    parameter int TW_W = 16,
    parameter int LS_W = 11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic                 reg_addr,
    input  logic [DATA_W-1:0]    reg_wdata,
    input  logic [NUM_FLAGS-1:0] ev,
    input  logic                 tx_in_lpi,
    input  logic                 rx_in_lpi,
    output lpi_cfg_t             cfg,
    output logic [TW_W-1:0]      tw,
    output logic [LS_W-1:0]      ls,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 irq
);
    typedef struct packed {
        lpi_cfg_t             cfg;
        logic [TW_W-1:0]      tw;
        logic [LS_W-1:0]      ls;
        logic [NUM_FLAGS-1:0] flags;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (reg_wr && !reg_addr) begin
            r_d.cfg.lpi_en  = reg_wdata[CB_LPI_EN];
            r_d.cfg.tx_auto = reg_wdata[CB_AUTO];
            r_d.cfg.link_ok = reg_wdata[CB_LINK];
            r_d.cfg.irq_en  = reg_wdata[CB_IRQ_EN];
        end
        if (reg_wr && reg_addr) begin
            r_d.tw = reg_wdata[TW_W-1:0];
            r_d.ls = reg_wdata[LS_LSB +: LS_W];
        end
        // Clearing read first, then new events, so none is lost
        if (reg_rd && !reg_addr) r_d.flags = '0;
        r_d.flags = r_d.flags | ev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (!reg_addr) begin
            reg_rdata[NUM_FLAGS-1:0] = r_q.flags;
            reg_rdata[STS_TX_LPI]    = tx_in_lpi;
            reg_rdata[STS_RX_LPI]    = rx_in_lpi;
            reg_rdata[CB_LPI_EN]     = r_q.cfg.lpi_en;
            reg_rdata[CB_AUTO]       = r_q.cfg.tx_auto;
            reg_rdata[CB_LINK]       = r_q.cfg.link_ok;
            reg_rdata[CB_IRQ_EN]     = r_q.cfg.irq_en;
        end else begin
            reg_rdata[TW_W-1:0]        = r_q.tw;
            reg_rdata[LS_LSB +: LS_W]  = r_q.ls;
        end
    end

    assign cfg   = r_q.cfg;
    assign tw    = r_q.tw;
    assign ls    = r_q.ls;
    assign flags = r_q.flags;
    assign irq   = r_q.cfg.irq_en & (|r_q.flags);
endmodule

// File: rtl/eee_lpi_fsm.sv
module eee_lpi_fsm
    import eee_lpi_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  lpi_cfg_t             cfg,
    input  logic                 tx_idle,
    input  logic                 tx_frame_req,
    input  logic                 rx_lpi,
    input  logic                 ls_met,
    input  logic                 tw_done,
    output lpi_state_e           state,
    output logic                 rx_in_lpi,
    output logic [NUM_FLAGS-1:0] ev
);
    typedef struct packed {
        lpi_state_e st;
        logic       rx_prev;
    } fsm_t;

    fsm_t f_d, f_q;
    logic want;
    logic auto_block;

    always_comb begin
        f_d        = f_q;
        ev         = '0;
        want       = (cfg.lpi_en | cfg.tx_auto) & cfg.link_ok;
        auto_block = cfg.tx_auto & (tx_frame_req | !tx_idle);
        case (f_q.st)
            ST_IDLE: begin
                if (want && ls_met && !auto_block) begin
                    f_d.st         = ST_LPI;
                    ev[FLG_TX_IN]  = 1'b1;
                end
            end
            ST_LPI: begin
                if (!want || (cfg.tx_auto && tx_frame_req)) begin
                    f_d.st         = ST_WAKE;
                    ev[FLG_TX_OUT] = 1'b1;
                end
            end
            ST_WAKE: begin
                if (tw_done) f_d.st = ST_IDLE;
            end
            default: f_d.st = ST_IDLE;
        endcase
        f_d.rx_prev    = rx_lpi;
        ev[FLG_RX_IN]  = rx_lpi & !f_q.rx_prev;
        ev[FLG_RX_OUT] = !rx_lpi & f_q.rx_prev;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '{st: ST_IDLE, rx_prev: 1'b0};
        else        f_q <= f_d;
    end

    assign state     = f_q.st;
    assign rx_in_lpi = f_q.rx_prev;
endmodule

// File: rtl/eee_lpi_ctrl.sv
module eee_lpi_ctrl
    import eee_lpi_pkg::*;
#(
    parameter int TW_W = 16,
    parameter int LS_W = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              us_tick,
    input  logic              ms_tick,
    input  logic              tx_idle,
    input  logic              tx_frame_req,
    input  logic              rx_lpi,
    output logic              tx_lpi_req,
    output logic              tx_resume_ok,
    output logic              irq
);
    lpi_cfg_t             cfg;
    logic [TW_W-1:0]      tw_val;
    logic [LS_W-1:0]      ls_val;
    logic [NUM_FLAGS-1:0] flags;
    logic [NUM_FLAGS-1:0] ev;
    logic [TW_W-1:0]      wake_cnt;
    logic [LS_W-1:0]      link_cnt;
    lpi_state_e           state;
    logic                 rx_in_lpi;
    logic                 ls_met;
    logic                 tw_done;
    logic                 in_lpi;

    assign in_lpi  = (state == ST_LPI);
    assign ls_met  = (link_cnt >= ls_val);
    assign tw_done = (wake_cnt >= tw_val);

    eee_lpi_regs #(.TW_W(TW_W), .LS_W(LS_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .ev(ev),
        .tx_in_lpi(in_lpi), .rx_in_lpi(rx_in_lpi),
        .cfg(cfg), .tw(tw_val), .ls(ls_val), .flags(flags),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    eee_lpi_tick_cnt #(.W(LS_W)) u_link_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(!cfg.link_ok), .tick(ms_tick), .count(link_cnt)
    );

    eee_lpi_tick_cnt #(.W(TW_W)) u_wake_cnt (
        .clk(clk), .rst_n(rst_n),
        .clr(state != ST_WAKE), .tick(us_tick), .count(wake_cnt)
    );

    eee_lpi_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cfg(cfg),
        .tx_idle(tx_idle), .tx_frame_req(tx_frame_req), .rx_lpi(rx_lpi),
        .ls_met(ls_met), .tw_done(tw_done),
        .state(state), .rx_in_lpi(rx_in_lpi), .ev(ev)
    );

    assign tx_lpi_req   = in_lpi;
    assign tx_resume_ok = (state == ST_IDLE);
endmodule

// File: rtl/eee_lpi_ctrl_chk.sv
module eee_lpi_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       tx_lpi_req,
    input logic       tx_resume_ok,
    input logic       reg_rd,
    input logic       reg_addr,
    input logic       link_ok,
    input logic       lpi_en,
    input logic       tx_auto,
    input logic       ls_met,
    input logic [3:0] flags,
    input logic [3:0] ev
);
    AST_ENTRY_NEEDS_LINK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi_req) |-> $past(link_ok) && $past(ls_met)); // R2

    AST_NO_ENTRY_LINK_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_lpi_req && !link_ok) |=> !tx_lpi_req); // R3

    AST_EXIT_NO_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lpi_req && !lpi_en && !tx_auto) |=> !tx_lpi_req); // R4

    AST_LPI_BLOCKS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        tx_lpi_req |-> !tx_resume_ok); // R6

    AST_WAKE_HOLDS_TX: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_lpi_req) |-> !tx_resume_ok); // R6

    AST_ENTRY_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_lpi_req) |-> flags[0]); // R7

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && !reg_addr && ev == 4'b0) |=> flags == 4'b0); // R8
endmodule

bind eee_lpi_ctrl eee_lpi_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_lpi_req(tx_lpi_req), .tx_resume_ok(tx_resume_ok),
    .reg_rd(reg_rd), .reg_addr(reg_addr),
    .link_ok(cfg.link_ok), .lpi_en(cfg.lpi_en), .tx_auto(cfg.tx_auto),
    .ls_met(ls_met), .flags(flags), .ev(ev)
);

// File: tb/eee_lpi_ctrl_tb.sv
`timescale 1ns/1ps
module eee_lpi_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        us_tick = 1'b0, ms_tick = 1'b0;
    logic        tx_idle = 1'b0, tx_frame_req = 1'b0, rx_lpi = 1'b0;
    logic        tx_lpi_req, tx_resume_ok, irq;
    int          n_chk = 0, n_fail = 0;

    localparam logic [31:0] MSK   = 32'h0000_030F;
    localparam logic [31:0] C_EN  = 32'h0001_0000;
    localparam logic [31:0] C_AU  = 32'h0002_0000;
    localparam logic [31:0] C_LK  = 32'h0004_0000;
    localparam logic [31:0] C_IE  = 32'h0008_0000;

    localparam logic [63:0] TMR_VEC [4] = '{
        {32'h0000_0000, 32'h0000_0000},
        {32'hFFFF_FFFF, 32'h07FF_FFFF},
        {32'h0123_4567, 32'h0123_4567},
        {32'h0ABC_DEF0, 32'h02BC_DEF0}
    };

    always #2.5 clk = ~clk;

    eee_lpi_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .us_tick(us_tick), .ms_tick(ms_tick), .tx_idle(tx_idle),
        .tx_frame_req(tx_frame_req), .rx_lpi(rx_lpi),
        .tx_lpi_req(tx_lpi_req), .tx_resume_ok(tx_resume_ok), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic a, input logic [31:0] d);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        step();
        reg_wr = 1'b0; reg_addr = 1'b0;
    endtask

    task automatic rd_ctrl(input string req, input logic [31:0] exp);
        reg_rd = 1'b1; reg_addr = 1'b0;
        #1;
        check(req, reg_rdata & MSK, exp);
        step();
        reg_rd = 1'b0;
    endtask

    task automatic pulse_us();
        us_tick = 1'b1; step(); us_tick = 1'b0;
    endtask

    task automatic pulse_ms();
        ms_tick = 1'b1; step(); ms_tick = 1'b0;
    endtask

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired (R10 run incomplete)");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R10 reset state
        check("R10 lpi_req", {31'b0, tx_lpi_req}, 32'd0);
        check("R10 resume", {31'b0, tx_resume_ok}, 32'd1);
        check("R10 irq", {31'b0, irq}, 32'd0);
        reg_addr = 1'b0; #1;
        check("R10 ctrl word", reg_rdata, 32'd0);
        reg_addr = 1'b1; #1;
        check("R10 timer word", reg_rdata, 32'd0);
        reg_addr = 1'b0;

        // R1 timer word layout, table walk
        for (int i = 0; i < 4; i++) begin
            wr(1'b1, TMR_VEC[i][63:32]);
            reg_addr = 1'b1; #1;
            check("R1 timer readback", reg_rdata, TMR_VEC[i][31:0]);
            reg_addr = 1'b0;
        end

        // LS=2 ms, TW=3 us
        wr(1'b1, 32'h0002_0003);
        wr(1'b0, C_EN | C_LK | C_IE);
        pulse_ms();
        repeat (3) step();
        check("R2 one tick short", {31'b0, tx_lpi_req}, 32'd0);
        wr(1'b0, C_EN | C_IE);
        step();
        check("R3 link down blocks", {31'b0, tx_lpi_req}, 32'd0);
        wr(1'b0, C_EN | C_LK | C_IE);
        pulse_ms();
        repeat (3) step();
        check("R2 count restarted", {31'b0, tx_lpi_req}, 32'd0);
        pulse_ms();
        check("R2 entry one cycle later", {31'b0, tx_lpi_req}, 32'd0);
        step();
        check("R2 entered", {31'b0, tx_lpi_req}, 32'd1);
        check("R6 no resume in lpi", {31'b0, tx_resume_ok}, 32'd0);
        check("R9 irq on entry", {31'b0, irq}, 32'd1);
        rd_ctrl("R7 entry flag", 32'h0000_0101);
        check("R8 irq cleared", {31'b0, irq}, 32'd0);
        rd_ctrl("R8 flags cleared", 32'h0000_0100);

        // R4 clear request forces exit, R6 wake window
        wr(1'b0, C_LK | C_IE);
        check("R4 still lpi", {31'b0, tx_lpi_req}, 32'd1);
        step();
        check("R4 exited", {31'b0, tx_lpi_req}, 32'd0);
        check("R6 wake hold", {31'b0, tx_resume_ok}, 32'd0);
        pulse_us(); pulse_us();
        repeat (2) step();
        check("R6 two ticks", {31'b0, tx_resume_ok}, 32'd0);
        pulse_us();
        check("R6 third tick", {31'b0, tx_resume_ok}, 32'd0);
        step();
        check("R6 resume", {31'b0, tx_resume_ok}, 32'd1);
        check("R9 irq on exit", {31'b0, irq}, 32'd1);
        rd_ctrl("R7 exit flag", 32'h0000_0002);

        // R8 event in the same cycle as clearing read
        rx_lpi = 1'b1;
        rd_ctrl("R8 read before event", 32'h0000_0000);
        rd_ctrl("R8 event kept", 32'h0000_0204);
        rx_lpi = 1'b0;
        step();
        rd_ctrl("R7 rx exit flag", 32'h0000_0008);

        // R9 masking
        wr(1'b0, C_LK);
        rx_lpi = 1'b1;
        step();
        check("R9 masked", {31'b0, irq}, 32'd0);
        wr(1'b0, C_LK | C_IE);
        check("R9 unmasked", {31'b0, irq}, 32'd1);
        rx_lpi = 1'b0;
        step();
        rd_ctrl("R7 rx flags", 32'h0000_000C);

        // R5 auto mode
        tx_idle = 1'b0;
        wr(1'b0, C_AU | C_LK | C_IE);
        repeat (4) step();
        check("R5 busy blocks", {31'b0, tx_lpi_req}, 32'd0);
        tx_idle = 1'b1;
        step();
        check("R5 idle enters", {31'b0, tx_lpi_req}, 32'd1);
        tx_idle = 1'b0; tx_frame_req = 1'b1;
        step();
        tx_frame_req = 1'b0;
        check("R5 frame exits", {31'b0, tx_lpi_req}, 32'd0);
        check("R5 wake hold", {31'b0, tx_resume_ok}, 32'd0);
        pulse_us(); pulse_us(); pulse_us();
        step();
        check("R6 resume after auto", {31'b0, tx_resume_ok}, 32'd1);
        rd_ctrl("R7 auto flags", 32'h0000_0003);

        // R3 link drop forces exit and blocks
        wr(1'b0, C_EN | C_LK | C_IE);
        step();
        check("R4 enable enters", {31'b0, tx_lpi_req}, 32'd1);
        wr(1'b0, C_EN | C_IE);
        step();
        check("R3 link drop exits", {31'b0, tx_lpi_req}, 32'd0);
        pulse_us(); pulse_us(); pulse_us();
        step();
        check("R3 resume", {31'b0, tx_resume_ok}, 32'd1);
        pulse_ms(); pulse_ms(); pulse_ms();
        repeat (3) step();
        check("R3 stays out", {31'b0, tx_lpi_req}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule